// File: doc/BRIEF.md
# LED Brightness PWM Sequencer

The block turns a requested LED brightness level into a configuration for one external PWM timer channel. It decides whether the LED pin is driven as a static level or handed over to the timer output. For dimmed levels it picks a clock prescaler and computes the period and duty compare values with a sequential divider. It then programs the timer through a simple single-beat write master.

Each request carries a brightness value. The clock rate, maximum brightness and refresh rate arrive on configuration ports and are captured when a request starts. Every request begins by stopping the timer channel. Fully off and fully on levels leave the timer stopped and drive the pin directly. Levels in between program the channel in a fixed order and start it last. A request that arrives while a sequence is running is held, and only the newest held request is processed next.

Top module: `led_pwm_seq`

## Requirements
- R1: A brightness of 0 yields a static pin (pin_fn_o=0) at level 0. The only write is the stop write. pin_fn_o and pin_lvl_o change only while busy_o is high.
- R2: A brightness equal to or above the maximum is clamped to the maximum. It yields a static pin (pin_fn_o=0) at level 1, and the only write is the stop write.
- R3: A refresh rate of 0 is treated as 100 in every computation.
- R4: The prescaler is the largest of 1, 4, 16 and 64 (codes 0 to 3) for which floor(rate/prescaler) is at least max × refresh. The code sits in bits 1:0 of the control word.
- R5: If the rate is below max × refresh for a dimmed level, err_o rises and only the stop write is issued. The pin is static at 0. err_o stays high until the next request is loaded.
- R6: Compare B receives the low 16 bits of floor(rate / (prescaler × refresh)).
- R7: Compare A receives the low 16 bits of floor((max − level) × periodB / max), where periodB is the full, untruncated period.
- R8: A dimmed level writes, in order: run=0, then control = 0x0040 | code, io = 0x0002, compare B, compare A, mode = 0x0002, and finally run=1 (data bit 0). The addresses are: run 0, control 1, mode 2, io 3, compare A 4, compare B 5.
- R9: Every request starts with a write of 0 to address 0 (run) before any other write.
- R10: bus_wr_o holds its address and data unchanged until a cycle with bus_ack_i high. Each acknowledged cycle completes exactly one write.
- R11: busy_o is high from the cycle after a request is accepted until the sequence ends. done_o is a one-cycle pulse at the end, and no write is issued while busy_o is low.
- R12: Requests arriving while busy are held. Only the latest one runs, right after the current sequence, and busy_o stays high across the hand-over.
- R13: A dimmed level leaves the pin in timer-function mode (pin_fn_o=1) with err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_rate_i | input | CLK_W | Timer input clock rate in Hz |
| max_brt_i | input | BRT_W | Maximum brightness level |
| refresh_i | input | REF_W | PWM refresh rate in Hz, 0 selects 100 |
| req_i | input | 1 | Brightness request strobe |
| brt_i | input | BRT_W | Requested brightness |
| bus_wr_o | output | 1 | Write request to the timer channel |
| bus_addr_o | output | 3 | Register address |
| bus_data_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Write acknowledge |
| pin_fn_o | output | 1 | 1 = pin driven by timer, 0 = static |
| pin_lvl_o | output | 1 | Static pin level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Clock rate too low for the requested resolution |

## Verification
A wrong prescaler choice or a faulty divider step shows up as a wrong data word on the control write or the compare writes. That happens within one sequence, about a hundred cycles after the request. A corrupted state register shows up as a missing, extra or reordered write, or as a pin mode that does not match the level class. Both are visible at the first done pulse. A lost or stale held request shows up as the wrong second sequence, or as an extra done pulse after the bench has gone quiet.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  localparam int REG_ADDR_W = 3;
  localparam int DEF_REFRESH = 100;

  localparam logic [REG_ADDR_W-1:0] A_RUN  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_CTL  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_MODE = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_IO   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_CMPA = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_CMPB = 3'd5;

  localparam logic [15:0] CTL_CLR_ON_B = 16'h0040;
  localparam logic [15:0] IO_CFG       = 16'h0002;
  localparam logic [15:0] MODE_PWM     = 16'h0002;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STOP, ST_DECIDE, ST_DIVP, ST_DIVA, ST_WCTL, ST_WIO,
    ST_WCMPB, ST_WCMPA, ST_WMODE, ST_WRUN, ST_END
  } seq_state_t;

endpackage

// File: rtl/pwm_seq_div.sv
module pwm_seq_div #(
  parameter int N_W = 40,
  parameter int D_W = 22
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem_q, den_q;
  logic [N_W-1:0]   quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [D_W:0]     trial;
  logic             take;

  always_comb begin
    trial = {rem_q, quo_q[N_W-1]};
    take  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(N_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (take) rem_q <= D_W'(trial - {1'b0, den_q});
        else      rem_q <= trial[D_W-1:0];
        quo_q <= {quo_q[N_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (rem_q < den_q)); // R6

endmodule

// File: rtl/pwm_ps_pick.sv
module pwm_ps_pick #(
  parameter int RATE_W   = 32,
  parameter int MIN_W    = 24,
  parameter int NUM_PS   = 4,
  parameter int PS_SHIFT = 2
) (
  input  logic [RATE_W-1:0]         rate_i,
  input  logic [MIN_W-1:0]          min_i,
  output logic [$clog2(NUM_PS)-1:0] code_o,
  output logic                      fail_o
);
  localparam int CODE_W = $clog2(NUM_PS);
  localparam int SH_W   = MIN_W + PS_SHIFT * (NUM_PS - 1);
  localparam int CMP_W  = (RATE_W > SH_W) ? RATE_W : SH_W;

  logic [NUM_PS-1:0] ok;

  for (genvar k = 0; k < NUM_PS; k++) begin : g_stage
    assign ok[k] = CMP_W'(rate_i) >= (CMP_W'(min_i) << (PS_SHIFT * k));
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < NUM_PS; k++) begin
      if (ok[k]) code_o = CODE_W'(k);
    end
    fail_o = !ok[0];
  end

endmodule

// File: rtl/led_pwm_seq.sv
module led_pwm_seq
  import led_pwm_pkg::*;
#(
  parameter int CLK_W    = 32,
  parameter int BRT_W    = 8,
  parameter int REF_W    = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_PS   = 4,
  parameter int PS_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CLK_W-1:0]      clk_rate_i,
  input  logic [BRT_W-1:0]      max_brt_i,
  input  logic [REF_W-1:0]      refresh_i,
  input  logic                  req_i,
  input  logic [BRT_W-1:0]      brt_i,
  output logic                  bus_wr_o,
  output logic [REG_ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]     bus_data_o,
  input  logic                  bus_ack_i,
  output logic                  pin_fn_o,
  output logic                  pin_lvl_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o
);
  localparam int MIN_W  = BRT_W + REF_W;
  localparam int NUM_W  = CLK_W + BRT_W;
  localparam int DEN_W  = REF_W + PS_SHIFT * (NUM_PS - 1);
  localparam int CODE_W = $clog2(NUM_PS);

  seq_state_t state_q;

  logic [CLK_W-1:0]  rate_q;
  logic [BRT_W-1:0]  max_q, brt_q, pend_brt_q;
  logic [REF_W-1:0]  ref_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] period_q, cmpa_q;
  logic              pend_q;

  logic              div_start_q, div_busy, div_done;
  logic [NUM_W-1:0]  div_num_q, div_quo;
  logic [DEN_W-1:0]  div_den_q, den_p;

  logic [MIN_W-1:0]  min_rate;
  logic [CODE_W-1:0] ps_code;
  logic              ps_fail;

  logic              do_load;
  logic [BRT_W-1:0]  ld_src, ld_brt;
  logic [REF_W-1:0]  ld_ref;

  logic                  is_wr;
  logic [REG_ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0]     wr_data;
  seq_state_t            wr_next;

  // Minimum count rate and prescaler choice
  assign min_rate = MIN_W'(max_q) * MIN_W'(ref_q);
  assign den_p    = DEN_W'(ref_q) << (PS_SHIFT * int'(ps_code));

  pwm_ps_pick #(
    .RATE_W  (CLK_W),
    .MIN_W   (MIN_W),
    .NUM_PS  (NUM_PS),
    .PS_SHIFT(PS_SHIFT)
  ) ps_i (
    .rate_i(rate_q),
    .min_i (min_rate),
    .code_o(ps_code),
    .fail_o(ps_fail)
  );

  pwm_seq_div #(
    .N_W(NUM_W),
    .D_W(DEN_W)
  ) div_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(div_start_q),
    .num_i  (div_num_q),
    .den_i  (div_den_q),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // Request loading: newest request wins at the end of a sequence
  always_comb begin
    do_load = (state_q == ST_IDLE && req_i) ||
              (state_q == ST_END && (req_i || pend_q));
    ld_src  = (state_q == ST_END && !req_i) ? pend_brt_q : brt_i;
    ld_brt  = (ld_src > max_brt_i) ? max_brt_i : ld_src;
    ld_ref  = (refresh_i == '0) ? REF_W'(DEF_REFRESH) : refresh_i;
  end

  // Write table: address, data and follow-on state per write state
  always_comb begin
    is_wr   = 1'b1;
    wr_addr = A_RUN;
    wr_data = '0;
    wr_next = ST_IDLE;
    case (state_q)
      ST_STOP:  begin wr_addr = A_RUN;  wr_data = '0;                                   wr_next = ST_DECIDE; end
      ST_WCTL:  begin wr_addr = A_CTL;  wr_data = DATA_W'(CTL_CLR_ON_B) | DATA_W'(code_q); wr_next = ST_WIO;  end
      ST_WIO:   begin wr_addr = A_IO;   wr_data = DATA_W'(IO_CFG);                      wr_next = ST_WCMPB;  end
      ST_WCMPB: begin wr_addr = A_CMPB; wr_data = period_q;                             wr_next = ST_WCMPA;  end
      ST_WCMPA: begin wr_addr = A_CMPA; wr_data = cmpa_q;                               wr_next = ST_WMODE;  end
      ST_WMODE: begin wr_addr = A_MODE; wr_data = DATA_W'(MODE_PWM);                    wr_next = ST_WRUN;   end
      ST_WRUN:  begin wr_addr = A_RUN;  wr_data = DATA_W'(1);                           wr_next = ST_END;    end
      default:  is_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rate_q      <= '0;
      max_q       <= '0;
      brt_q       <= '0;
      ref_q       <= REF_W'(DEF_REFRESH);
      pend_brt_q  <= '0;
      pend_q      <= 1'b0;
      code_q      <= '0;
      period_q    <= '0;
      cmpa_q      <= '0;
      div_start_q <= 1'b0;
      div_num_q   <= '0;
      div_den_q   <= '0;
      bus_wr_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_data_o  <= '0;
      pin_fn_o    <= 1'b0;
      pin_lvl_o   <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      div_start_q <= 1'b0;

      if (state_q != ST_IDLE && req_i) begin
        pend_q     <= 1'b1;
        pend_brt_q <= brt_i;
      end

      if (is_wr) begin
        if (!bus_wr_o) begin
          bus_wr_o   <= 1'b1;
          bus_addr_o <= wr_addr;
          bus_data_o <= wr_data;
        end else if (bus_ack_i) begin
          bus_wr_o <= 1'b0;
          state_q  <= wr_next;
        end
      end

      case (state_q)
        ST_DECIDE: begin
          if (brt_q == '0 || brt_q == max_q) begin
            pin_fn_o  <= 1'b0;
            pin_lvl_o <= (brt_q != '0);
            state_q   <= ST_END;
          end else if (ps_fail) begin
            err_o     <= 1'b1;
            pin_fn_o  <= 1'b0;
            pin_lvl_o <= 1'b0;
            state_q   <= ST_END;
          end else begin
            pin_fn_o    <= 1'b1;
            pin_lvl_o   <= 1'b0;
            code_q      <= ps_code;
            div_num_q   <= NUM_W'(rate_q);
            div_den_q   <= den_p;
            div_start_q <= 1'b1;
            state_q     <= ST_DIVP;
          end
        end
        ST_DIVP: begin
          if (div_done) begin
            period_q    <= div_quo[DATA_W-1:0];
            div_num_q   <= NUM_W'(max_q - brt_q) * NUM_W'(div_quo[CLK_W-1:0]);
            div_den_q   <= DEN_W'(max_q);
            div_start_q <= 1'b1;
            state_q     <= ST_DIVA;
          end
        end
        ST_DIVA: begin
          if (div_done) begin
            cmpa_q  <= div_quo[DATA_W-1:0];
            state_q <= ST_WCTL;
          end
        end
        ST_END: begin
          done_o <= 1'b1;
          if (!do_load) begin
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase

      if (do_load) begin
        brt_q   <= ld_brt;
        max_q   <= max_brt_i;
        rate_q  <= clk_rate_i;
        ref_q   <= ld_ref;
        err_o   <= 1'b0;
        busy_o  <= 1'b1;
        state_q <= ST_STOP;
        if (state_q == ST_END) pend_q <= 1'b0;
      end
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o && !bus_ack_i |=> bus_wr_o && $stable(bus_addr_o) && $stable(bus_data_o)); // R10
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o |-> busy_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !(bus_wr_o && bus_addr_o == A_RUN && bus_data_o[0])); // R5
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !$past(busy_o) |-> $stable(pin_fn_o) && $stable(pin_lvl_o)); // R1
  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    div_start_q |-> !div_busy); // R6
  AST_QUO_FITS: assert property (@(posedge clk) disable iff (rst)
    div_done |-> div_quo[NUM_W-1:CLK_W] == '0); // R7

endmodule

// File: tb/led_pwm_seq_tb.sv
module led_pwm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rate = 32'd0;
  logic [7:0]  maxb = 8'd0;
  logic [15:0] refr = 16'd0;
  logic        req = 1'b0;
  logic [7:0]  brt = 8'd0;
  logic        ack = 1'b0;
  logic        bus_wr_o, pin_fn_o, pin_lvl_o, busy_o, done_o, err_o;
  logic [2:0]  bus_addr_o;
  logic [15:0] bus_data_o;

  always #4 clk = ~clk;

  led_pwm_seq dut_i (
    .clk(clk), .rst(rst), .clk_rate_i(rate), .max_brt_i(maxb), .refresh_i(refr),
    .req_i(req), .brt_i(brt), .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o),
    .bus_data_o(bus_data_o), .bus_ack_i(ack), .pin_fn_o(pin_fn_o),
    .pin_lvl_o(pin_lvl_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int total = 0;
  int fail  = 0;
  int cyc   = 0;

  // Acknowledge model, write log, done counter, hold monitor
  int          log_n = 0;
  int          log_a [1024];
  int          log_d [1024];
  int          done_cnt = 0;
  int          hold_err = 0;
  int          wcnt = 0;
  bit          seen = 1'b0;
  logic [2:0]  pa;
  logic [15:0] pd;

  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (ack) begin
      ack  = 1'b0;
      seen = 1'b0;
      wcnt = int'($urandom % 3);
    end else if (bus_wr_o) begin
      if (seen && (bus_addr_o != pa || bus_data_o != pd)) hold_err++;
      seen = 1'b1;
      pa = bus_addr_o;
      pd = bus_data_o;
      if (wcnt == 0) begin
        ack = 1'b1;
        if (log_n < 1024) begin
          log_a[log_n] = int'(bus_addr_o);
          log_d[log_n] = int'(bus_data_o);
        end
        log_n++;
      end else begin
        wcnt--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", total - fail, total + 1);
      $finish;
    end
  end

  int exp_n;
  int exp_a [32];
  int exp_d [32];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference model: kind 0 off, 1 on, 2 error, 3 dimmed
  task automatic model(input int b_in, output int kind, output int code,
                       output longint per, output longint cmpa);
    longint r, m, rf, b, minr;
    r  = longint'(rate);
    m  = longint'(maxb);
    rf = (refr == 16'd0) ? 100 : longint'(refr);
    b  = (longint'(b_in) > m) ? m : longint'(b_in);
    minr = m * rf;
    code = 0; per = 0; cmpa = 0;
    if (b == 0) kind = 0;
    else if (b == m) kind = 1;
    else if (r < minr) kind = 2;
    else begin
      kind = 3;
      for (int k = 0; k < 4; k++)
        if (r >= minr * (longint'(1) << (2 * k))) code = k;
      per  = r / ((longint'(1) << (2 * code)) * rf);
      cmpa = (m - b) * per / m;
    end
  endtask

  task automatic push(input int a, input int d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic add_exp(input int b, output int kind);
    int code;
    longint per, cmpa;
    model(b, kind, code, per, cmpa);
    push(0, 0);
    if (kind == 3) begin
      push(1, 'h40 | code);
      push(3, 2);
      push(5, int'(per & 'hffff));
      push(4, int'(cmpa & 'hffff));
      push(2, 2);
      push(0, 1);
    end
  endtask

  function automatic string etag(input int idx, input int first);
    int i;
    i = idx - first;
    if (i == 0) return "R9";
    if (i == 1) return "R4";
    if (i == 3) return "R6";
    if (i == 4) return "R7";
    return "R8";
  endfunction

  task automatic check_log(input int base);
    int k;
    chk(log_n - base == exp_n, "R8 write count", log_n - base, exp_n);
    k = 0;
    for (int i = 0; i < exp_n; i++) begin
      if (i > 0 && exp_a[i] == 0 && exp_d[i] == 0) k = i;
      if (base + i < log_n) begin
        chk(log_a[base+i] == exp_a[i], {etag(i, k), " addr"}, log_a[base+i], exp_a[i]);
        chk(log_d[base+i] == exp_d[i], {etag(i, k), " data"}, log_d[base+i], exp_d[i]);
      end
    end
  endtask

  task automatic check_pins(input int kind);
    case (kind)
      0: begin
        chk(pin_fn_o == 1'b0, "R1 pin_fn", pin_fn_o, 0);
        chk(pin_lvl_o == 1'b0, "R1 pin_lvl", pin_lvl_o, 0);
      end
      1: begin
        chk(pin_fn_o == 1'b0, "R2 pin_fn", pin_fn_o, 0);
        chk(pin_lvl_o == 1'b1, "R2 pin_lvl", pin_lvl_o, 1);
      end
      2: begin
        chk(pin_fn_o == 1'b0, "R5 pin_fn", pin_fn_o, 0);
        chk(pin_lvl_o == 1'b0, "R5 pin_lvl", pin_lvl_o, 0);
      end
      default: chk(pin_fn_o == 1'b1, "R13 pin_fn", pin_fn_o, 1);
    endcase
    chk(err_o == (kind == 2), "R5 err", err_o, kind == 2);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run_req(input int b);
    int base, kind;
    exp_n = 0;
    add_exp(b, kind);
    base = log_n;
    @(negedge clk);
    req = 1'b1;
    brt = 8'(b);
    @(negedge clk);
    req = 1'b0;
    chk(busy_o == 1'b1, "R11 busy after request", busy_o, 1);
    wait_done();
    chk(busy_o == 1'b0, "R11 busy at done", busy_o, 0);
    check_pins(kind);
    check_log(base);
    @(negedge clk);
    chk(done_o == 1'b0, "R11 done pulse width", done_o, 0);
  endtask

  task automatic run_pending(input int a, input int b, input int c);
    int base, kind, dbase;
    exp_n = 0;
    add_exp(a, kind);
    add_exp(c, kind);
    base  = log_n;
    dbase = done_cnt;
    @(negedge clk);
    req = 1'b1; brt = 8'(a);
    @(negedge clk);
    brt = 8'(b);
    @(negedge clk);
    brt = 8'(c);
    @(negedge clk);
    req = 1'b0;
    wait_done();
    chk(busy_o == 1'b1, "R12 busy across hand-over", busy_o, 1);
    wait_done();
    check_pins(kind);
    check_log(base);
    repeat (150) @(negedge clk);
    chk(done_cnt - dbase == 2, "R12 sequence count", done_cnt - dbase, 2);
    chk(log_n - base == exp_n, "R12 no extra writes", log_n - base, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && bus_wr_o == 1'b0 && done_o == 1'b0, "R11 reset idle",
        {busy_o, bus_wr_o, done_o}, 0);
    chk(pin_fn_o == 1'b0 && pin_lvl_o == 1'b0 && err_o == 1'b0, "R1 reset pins",
        {pin_fn_o, pin_lvl_o, err_o}, 0);

    rate = 32'd160000; maxb = 8'd100; refr = 16'd100;
    run_req(0);     // R1
    run_req(100);   // R2
    run_req(200);   // R2 clamp
    run_req(30);    // R4 code 2, R6, R7, R8
    rate = 32'd159999;
    run_req(30);    // R4 code 1 boundary
    rate = 32'd640000;
    run_req(1);     // R4 code 3
    refr = 16'd0; rate = 32'd1000000;
    run_req(55);    // R3
    rate = 32'd9999; refr = 16'd100;
    run_req(50);    // R5 error
    rate = 32'd10000;
    run_req(50);    // R5 cleared, R4 code 0
    rate = 32'd12345678; maxb = 8'd200; refr = 16'd60;
    run_pending(77, 3, 150); // R12

    for (int n = 0; n < 40; n++) begin
      rate = $urandom_range(2000000, 1000);
      maxb = 8'($urandom_range(255, 1));
      refr = 16'($urandom_range(400, 0));
      run_req(int'($urandom_range(int'(maxb) + 3, 0)));
    end

    chk(hold_err == 0, "R10 write held until ack", hold_err, 0);
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule